// File: doc/BRIEF.md
# Transition-to-Level Handshake Latch Controller

This block sits between a producer that signals with transitions and a level-sensitive data latch that needs return-to-zero style control. The producer flips its request level once for each new data word and holds the data bundled with it. Either direction of flip counts as one request. The block closes its latch on the word, then flips both its acknowledge to the producer and its request to the consumer, so each request gives exactly one transition on each. When the consumer answers by flipping its acknowledge to match, the latch reopens and the block waits for the next request, which will be the flip in the opposite direction.

Neither request nor acknowledge ever returns to zero. A request is outstanding exactly when the producer's request level differs from the block's acknowledge level. A request that arrives while the latch is still closed therefore stays outstanding and is served as soon as the latch reopens. All inputs are sampled on the rising clock edge, and all outputs are registers updated on that edge. The data output always shows the latch content. While the latch is open, that content follows the input bus one cycle late.

Top module: `twophase_latch_ctl`

## Requirements
- R1: While reset is high, the producer acknowledge, the consumer request, the latch-closed flag and the data output are all 0, so the latch is open.
- R2: With the latch open, a sampled request level that differs from the producer acknowledge is a request, whichever direction it flipped. With the latch open and the two levels equal, neither handshake output changes.
- R3: On the edge that accepts a request, the latch-closed flag goes to 1 and the data output takes the data input sampled on that edge.
- R4: While the latch is closed, the data output does not change, whatever the data input does.
- R5: While the latch is closed, a consumer acknowledge level equal to the consumer request makes the latch-closed flag go to 0 on the next edge.
- R6: While the latch is open, on every edge the data output takes the data input sampled on that edge.
- R7: A request flip seen while the latch is closed causes no handshake output change while the latch stays closed. It is accepted on the first edge after the latch reopens, with the data input present on that edge.
- R8: The producer acknowledge and the consumer request flip together on each accepted request and always hold equal levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Producer request level; each flip is one request |
| data_i | input | W | Data bundled with the producer request |
| cack_i | input | 1 | Consumer acknowledge level; a flip to match creq_o frees the latch |
| pack_o | output | 1 | Acknowledge to the producer; flips once per accepted request |
| creq_o | output | 1 | Request to the consumer; flips once per accepted request |
| data_o | output | W | Latch content |
| latch_closed_o | output | 1 | 1 while the latch holds a word, 0 while it is open |

## Verification
A wrong steering phase shows at once as a missing or doubled flip on pack_o and creq_o. It is visible on the edge that should accept a request, or as a spurious flip on an idle edge. A wrong open/closed state shows within one cycle: data_o tracks data_i while it should hold, or it freezes while it should track. A lost pending request shows as latch_closed_o staying low on the edge after the latch reopens. The sweep covers both request polarities, consumer delays of zero to three cycles, and requests issued early during the hold, so each of these faults appears at its own cycle.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

    typedef enum logic {
        LAT_OPEN = 1'b0,
        LAT_SHUT = 1'b1
    } lat_st_e;

    typedef struct packed {
        lat_st_e st;
        logic    phase;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: LAT_OPEN, phase: 1'b0};

    function automatic logic flip(input logic b);
        return ~b;
    endfunction

    function automatic logic levels_differ(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/edge_sense.sv
`timescale 1ns/1ps
module edge_sense
    import hs_pkg::*;
(
    input  logic req_i,
    input  logic cack_i,
    input  logic phase,
    output logic req_pend,
    output logic ack_done
);
    // an outstanding request is a level mismatch; polarity is irrelevant
    always_comb begin
        req_pend = levels_differ(req_i, phase);
        ack_done = ~levels_differ(cack_i, phase);
    end
endmodule

// File: rtl/steer_ctl.sv
`timescale 1ns/1ps
module steer_ctl
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_pend,
    input  logic ack_done,
    output logic phase,
    output logic shut
);
    ctl_t cur, nxt;

    always_comb begin
        nxt = cur;
        case (cur.st)
            LAT_OPEN: if (req_pend) begin
                nxt.st    = LAT_SHUT;
                nxt.phase = flip(cur.phase);
            end
            LAT_SHUT: if (ack_done) begin
                nxt.st = LAT_OPEN;
            end
            default: nxt = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CTL_RESET;
        else     cur <= nxt;
    end

    assign phase = cur.phase;
    assign shut  = (cur.st == LAT_SHUT);
endmodule

// File: rtl/data_hold.sv
`timescale 1ns/1ps
module data_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/twophase_latch_ctl.sv
`timescale 1ns/1ps
module twophase_latch_ctl
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_i,
    input  logic [W-1:0] data_i,
    input  logic         cack_i,
    output logic         pack_o,
    output logic         creq_o,
    output logic [W-1:0] data_o,
    output logic         latch_closed_o
);
    logic phase, shut, req_pend, ack_done;

    edge_sense u_sense (
        .req_i   (req_i),
        .cack_i  (cack_i),
        .phase   (phase),
        .req_pend(req_pend),
        .ack_done(ack_done)
    );

    steer_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .req_pend(req_pend),
        .ack_done(ack_done),
        .phase   (phase),
        .shut    (shut)
    );

    // open latch loads every edge, including the capturing one
    data_hold #(.W(W)) u_hold (
        .clk (clk),
        .rst (rst),
        .load(~shut),
        .d   (data_i),
        .q   (data_o)
    );

    assign pack_o         = phase;
    assign creq_o         = phase;
    assign latch_closed_o = shut;
endmodule

// File: rtl/twophase_latch_ctl_chk.sv
`timescale 1ns/1ps
module twophase_latch_ctl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         req_i,
    input logic [W-1:0] data_i,
    input logic         cack_i,
    input logic         pack_o,
    input logic         creq_o,
    input logic [W-1:0] data_o,
    input logic         latch_closed_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!pack_o && !creq_o && !latch_closed_o && data_o == '0));

    // R2
    idle_no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!latch_closed_o && req_i == pack_o) |=> ($stable(pack_o) && !latch_closed_o));

    // R3
    accept_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!latch_closed_o && req_i != pack_o) |=>
            (latch_closed_o && pack_o != $past(pack_o) && data_o == $past(data_i)));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        latch_closed_o |=> $stable(data_o));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_closed_o && cack_i == creq_o) |=> !latch_closed_o);

    // R6
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_closed_o |=> (data_o == $past(data_i)));

    // R7
    pending_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        latch_closed_o |=> $stable(pack_o));

    // R8
    pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
        pack_o == creq_o);
endmodule

bind twophase_latch_ctl twophase_latch_ctl_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .data_i        (data_i),
    .cack_i        (cack_i),
    .pack_o        (pack_o),
    .creq_o        (creq_o),
    .data_o        (data_o),
    .latch_closed_o(latch_closed_o)
);

// File: tb/twophase_latch_ctl_tb.sv
`timescale 1ns/1ps
module twophase_latch_ctl_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic         cack_i = 1'b0;
    logic         pack_o, creq_o, latch_closed_o;
    logic [W-1:0] data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    twophase_latch_ctl #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .data_i(data_i), .cack_i(cack_i),
        .pack_o(pack_o), .creq_o(creq_o), .data_o(data_o),
        .latch_closed_o(latch_closed_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] word_of(input int i);
        return W'(i * 37 + 5);
    endfunction

    initial begin
        logic exp_ack;
        logic [W-1:0] d;
        logic [W-1:0] x;
        bit pre;
        exp_ack = 1'b0;
        pre = 0;

        // R1: reset values
        data_i = 8'hA5;
        repeat (3) @(negedge clk);
        chk(pack_o == 1'b0 && creq_o == 1'b0, "R1 handshake", {pack_o, creq_o}, 0);
        chk(latch_closed_o == 1'b0, "R1 closed flag", latch_closed_o, 0);
        chk(data_o == '0, "R1 data", data_o, 0);
        rst = 1'b0;
        @(negedge clk);
        // R6: first open edge loads the bus
        chk(data_o == 8'hA5, "R6 after reset", data_o, 8'hA5);

        for (int i = 0; i < 64; i++) begin
            d = word_of(i);
            if (!pre) begin
                data_i = d;
                req_i  = ~req_i;
            end
            @(negedge clk);
            exp_ack = ~exp_ack;
            // R2 / R3 / R8: one flip per request, either polarity
            chk(latch_closed_o == 1'b1, "R3 closed on accept", latch_closed_o, 1);
            chk(pack_o == exp_ack, "R2 ack flip", pack_o, exp_ack);
            chk(creq_o == exp_ack, "R8 creq flip", creq_o, exp_ack);
            chk(data_o == d, "R3 captured data", data_o, d);

            pre = i[0];
            if (pre) begin
                // R7: early request while the latch is closed
                req_i  = ~req_i;
                data_i = word_of(i + 1);
            end else begin
                data_i = ~d;
            end

            for (int k = 0; k < (i % 4); k++) begin
                @(negedge clk);
                chk(latch_closed_o == 1'b1, "R5 stays closed", latch_closed_o, 1);
                chk(data_o == d, "R4 hold data", data_o, d);
                chk(pack_o == exp_ack, "R7 no flip while closed", pack_o, exp_ack);
                if (!pre) data_i = data_i + 8'h11;
            end

            cack_i = exp_ack;
            @(negedge clk);
            chk(latch_closed_o == 1'b0, "R5 reopen", latch_closed_o, 0);
            chk(data_o == d, "R4 data at release", data_o, d);
            chk(pack_o == exp_ack, "R7 quiet at release", pack_o, exp_ack);

            if (!pre) begin
                for (int k = 0; k < 2; k++) begin
                    x = W'(i * 13 + k * 71 + 3);
                    data_i = x;
                    @(negedge clk);
                    chk(data_o == x, "R6 transparent", data_o, x);
                    chk(pack_o == exp_ack && !latch_closed_o,
                        "R2 idle no flip", {latch_closed_o, pack_o}, {1'b0, exp_ack});
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule